// File: doc/BRIEF.md
# Sleep, Reset and Boot Control

This block sits on the host side of a wireless core and decides three things for it: whether the core is asked to be awake, whether it is held in soft reset, and whether its embedded processor is halted. The host reaches it through a simple 32-bit register port: a write strobe, an address and write data, with read data returned combinationally for the current address. Three outputs leave the block: `wakeReq`, `coreRst` and `cpuHalt`. Two status inputs come back. `coreReady` is the core's own readiness flag. `bootStrap` is a board strap that chooses the boot mode.

A wake request is not acknowledged at once. A wake timer, loaded from a host-programmable delay register, must run out before the sleep register reports readiness. This stands in for oscillator and PLL settling. Soft reset is a plain level held by the host. The host registers live outside the reset domain they control, so they keep their contents while the core is in soft reset. The processor halt bit takes its power-on value from the inverted strap. A host that downloads firmware first sets halt and then clears it to start execution.

Top module: `sleep_boot_ctl`

## Requirements
- R1: Writing a value with bit 0 set to the sleep register (offset 0x00) raises `wakeReq` and bit 0 of that register on the next cycle. Writing a value with bit 0 clear lowers both on the next cycle.
- R2: Bit 2 of the sleep register is the ready flag. It reads 1 only while `wakeReq` is high, `coreReady` is high, and the programmed delay of D cycles has passed since the wake command. The flag first reads 1 after the D-th clock edge that follows the write edge, so an awake and ready core reads back 0x5.
- R3: A sleep command clears the ready flag on the next cycle, whatever the state of the timer.
- R4: Bit 0 of the soft-reset register (offset 0x04) drives `coreRst`. It is a level that stays set until the host writes 0 to it.
- R5: While `coreRst` is high the ready flag reads 0 and the wake timer is held at zero. After release the full delay is counted again from the release edge.
- R6: Soft reset leaves the sleep, halt and delay registers unchanged.
- R7: While the hardware reset `rst` is high, the halt bit loads the inverse of `bootStrap`. A 1 on `cpuHalt` halts the processor.
- R8: Bit 0 of the halt register (offset 0x08) drives `cpuHalt` and changes only when the host writes that register.
- R9: The delay register (offset 0x0C) holds DLY_W bits, reset value DLY_RST (16 by default). A delay of 0 makes the ready flag read 1 in the cycle right after the wake write.
- R10: Reserved bits of every register read as 0, and writes to them are dropped. An unmapped address reads 0, and writing to it changes no register.
- R11: Writing wake again while already awake does not restart the wake timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous hardware reset, active high |
| regWe | input | 1 | Register write strobe |
| regAddr | input | ADDR_W | Byte address of the register |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data for `regAddr` (combinational) |
| coreReady | input | 1 | Readiness indication from the core |
| bootStrap | input | 1 | Boot strap pin; inverted into the halt reset value |
| coreRst | output | 1 | Core soft reset, level |
| cpuHalt | output | 1 | Embedded processor halt |
| wakeReq | output | 1 | Wake request to the core clocking |

## Verification
The hardest case to reach is the interaction between soft reset and the wake timer. The ready flag must stay low for the whole reset period, and once reset is released the full delay must be counted again from the release edge, not from the original wake command. The stimulus reaches this case in two steps. First it programs a short delay and lets the core become ready. Then it asserts soft reset, holds it for several cycles, releases it, and samples the sleep register on each of the following cycles until the flag returns. A bench model updated on every edge also catches off-by-one errors in the timer at every other address.

// File: rtl/sleep_boot_pkg.sv
package sleep_boot_pkg;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_SLEEP,
    SEL_RST,
    SEL_HALT,
    SEL_DLY
  } readSelT;

  typedef struct packed {
    logic    wrSleep;
    logic    wrRst;
    logic    wrHalt;
    logic    wrDly;
    readSelT rdSel;
  } strobeT;

  localparam int WAKE_BIT  = 0;
  localparam int READY_BIT = 2;

endpackage

// File: rtl/sleep_boot_ctrl.sv
module sleep_boot_ctrl
  import sleep_boot_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int OFS_SLEEP = 'h00,
  parameter int OFS_RST   = 'h04,
  parameter int OFS_HALT  = 'h08,
  parameter int OFS_DLY   = 'h0C
) (
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  output strobeT            strobes
);

  localparam logic [ADDR_W-1:0] A_SLEEP = ADDR_W'(OFS_SLEEP);
  localparam logic [ADDR_W-1:0] A_RST   = ADDR_W'(OFS_RST);
  localparam logic [ADDR_W-1:0] A_HALT  = ADDR_W'(OFS_HALT);
  localparam logic [ADDR_W-1:0] A_DLY   = ADDR_W'(OFS_DLY);

  always_comb begin
    strobes = '0;
    strobes.rdSel = SEL_NONE;
    unique case (regAddr)
      A_SLEEP: begin strobes.rdSel = SEL_SLEEP; strobes.wrSleep = regWe; end
      A_RST:   begin strobes.rdSel = SEL_RST;   strobes.wrRst   = regWe; end
      A_HALT:  begin strobes.rdSel = SEL_HALT;  strobes.wrHalt  = regWe; end
      A_DLY:   begin strobes.rdSel = SEL_DLY;   strobes.wrDly   = regWe; end
      default: strobes.rdSel = SEL_NONE;
    endcase
  end

endmodule

// File: rtl/sleep_boot_timer.sv
module sleep_boot_timer #(
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic [DLY_W-1:0] limit,
  output logic             done
);

  logic [DLY_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt <= '0;
    end else if (cnt < limit) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign done = (cnt >= limit);

endmodule

// File: rtl/sleep_boot_dp.sv
module sleep_boot_dp
  import sleep_boot_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int DLY_W   = 8,
  parameter int DLY_RST = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  strobeT            strobes,
  input  logic [DLY_W-1:0]  wrData,
  input  logic              coreReady,
  input  logic              bootStrap,
  output logic [DATA_W-1:0] rdData,
  output logic              coreRst,
  output logic              cpuHalt,
  output logic              wakeReq
);

  logic             wakeQ;
  logic             rstQ;
  logic             haltQ;
  logic [DLY_W-1:0] dlyQ;
  logic             startWake;
  logic             goSleep;
  logic             timerClear;
  logic             delayDone;
  logic             readyNow;

  assign startWake  = strobes.wrSleep & wrData[WAKE_BIT] & ~wakeQ;
  assign goSleep    = strobes.wrSleep & ~wrData[WAKE_BIT];
  assign timerClear = startWake | goSleep | rstQ | ~wakeQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      wakeQ <= 1'b0;
      rstQ  <= 1'b0;
      haltQ <= ~bootStrap;
      dlyQ  <= DLY_W'(DLY_RST);
    end else begin
      if (strobes.wrSleep) wakeQ <= wrData[WAKE_BIT];
      if (strobes.wrRst)   rstQ  <= wrData[0];
      if (strobes.wrHalt)  haltQ <= wrData[0];
      if (strobes.wrDly)   dlyQ  <= wrData;
    end
  end

  sleep_boot_timer #(.DLY_W(DLY_W)) wakeTimer (
    .clk  (clk),
    .rst  (rst),
    .clear(timerClear),
    .limit(dlyQ),
    .done (delayDone)
  );

  assign readyNow = wakeQ & ~rstQ & coreReady & delayDone;

  always_comb begin
    rdData = '0;
    case (strobes.rdSel)
      SEL_SLEEP: begin
        rdData[WAKE_BIT]  = wakeQ;
        rdData[READY_BIT] = readyNow;
      end
      SEL_RST:  rdData[0] = rstQ;
      SEL_HALT: rdData[0] = haltQ;
      SEL_DLY:  rdData[DLY_W-1:0] = dlyQ;
      default:  rdData = '0;
    endcase
  end

  assign coreRst = rstQ;
  assign cpuHalt = haltQ;
  assign wakeReq = wakeQ;

  AST_SLEEP_DROPS_READY: assert property (@(posedge clk) disable iff (rst)
    (strobes.wrSleep && !wrData[WAKE_BIT]) |=> !readyNow); // R3

  AST_RST_IS_LEVEL: assert property (@(posedge clk) disable iff (rst)
    !strobes.wrRst |=> $stable(rstQ)); // R4

  AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !strobes.wrHalt |=> $stable(haltQ)); // R8

  AST_WAKE_WAITS: assert property (@(posedge clk) disable iff (rst)
    (startWake && dlyQ != '0) |=> !readyNow); // R2

  AST_STRAP_HALT: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (haltQ == !$past(bootStrap))); // R7

  AST_DLY_KEPT_IN_RST: assert property (@(posedge clk) disable iff (rst)
    (rstQ && !strobes.wrDly) |=> $stable(dlyQ)); // R6

endmodule

// File: rtl/sleep_boot_ctl.sv
module sleep_boot_ctl
  import sleep_boot_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int DLY_W   = 8,
  parameter int DLY_RST = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  input  logic              coreReady,
  input  logic              bootStrap,
  output logic              coreRst,
  output logic              cpuHalt,
  output logic              wakeReq
);

  localparam int DATA_W = 32;

  strobeT strobes;
  logic   unusedWdata;

  assign unusedWdata = ^regWdata[DATA_W-1:DLY_W];

  sleep_boot_ctrl #(.ADDR_W(ADDR_W)) ctrl (
    .regWe  (regWe),
    .regAddr(regAddr),
    .strobes(strobes)
  );

  sleep_boot_dp #(
    .DATA_W (DATA_W),
    .DLY_W  (DLY_W),
    .DLY_RST(DLY_RST)
  ) dp (
    .clk      (clk),
    .rst      (rst),
    .strobes  (strobes),
    .wrData   (regWdata[DLY_W-1:0]),
    .coreReady(coreReady),
    .bootStrap(bootStrap),
    .rdData   (regRdata),
    .coreRst  (coreRst),
    .cpuHalt  (cpuHalt),
    .wakeReq  (wakeReq)
  );

endmodule

// File: tb/sleep_boot_ctl_test.sv
`timescale 1ns/1ps
module sleep_boot_ctl_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        regWe = 1'b0;
  logic [7:0]  regAddr = 8'h00;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        coreReady = 1'b1;
  logic        bootStrap = 1'b1;
  logic        coreRst, cpuHalt, wakeReq;

  int tests = 0;
  int fails = 0;
  bit finished = 0;

  // behavioural reference state
  int mWake = 0, mRst = 0, mHalt = 0, mDly = 16, mCnt = 0;

  always #4 clk = ~clk;

  sleep_boot_ctl uut (
    .clk(clk), .rst(rst), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .coreReady(coreReady),
    .bootStrap(bootStrap), .coreRst(coreRst), .cpuHalt(cpuHalt),
    .wakeReq(wakeReq)
  );

  function automatic int modelReady();
    return (mWake != 0 && mRst == 0 && coreReady && mCnt >= mDly) ? 1 : 0;
  endfunction

  function automatic logic [31:0] modelRead(input logic [7:0] a);
    case (a)
      8'h00: return 32'(mWake) | (32'(modelReady()) << 2);
      8'h04: return 32'(mRst);
      8'h08: return 32'(mHalt);
      8'h0C: return 32'(mDly);
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk) begin
    int nWake, nRst, nHalt, nDly, nCnt;
    if (rst) begin
      nWake = 0; nRst = 0; nHalt = bootStrap ? 0 : 1; nDly = 16; nCnt = 0;
    end else begin
      nWake = mWake; nRst = mRst; nHalt = mHalt; nDly = mDly;
      if (mWake == 0 || mRst != 0) nCnt = 0;
      else if (mCnt < mDly) nCnt = mCnt + 1;
      else nCnt = mCnt;
      if (regWe) begin
        case (regAddr)
          8'h00: begin
            if (regWdata[0] != mWake[0]) nCnt = 0;
            nWake = int'(regWdata[0]);
          end
          8'h04: nRst = int'(regWdata[0]);
          8'h08: nHalt = int'(regWdata[0]);
          8'h0C: nDly = int'(regWdata[7:0]);
          default: ;
        endcase
      end
    end
    mWake = nWake; mRst = nRst; mHalt = nHalt; mDly = nDly; mCnt = nCnt;
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst && !finished) begin
      logic [31:0] exp;
      exp = modelRead(regAddr);
      tests++;
      if (regRdata !== exp) begin
        fails++;
        $display("FAIL %s cycle compare addr %h: got %h exp %h",
                 (regAddr == 8'h00) ? "R2" : (regAddr == 8'h04) ? "R4" :
                 (regAddr == 8'h08) ? "R8" : (regAddr == 8'h0C) ? "R9" : "R10",
                 regAddr, regRdata, exp);
      end
      tests++;
      if (wakeReq !== mWake[0] || coreRst !== mRst[0] || cpuHalt !== mHalt[0]) begin
        fails++;
        $display("FAIL R1 outputs wake/rst/halt: got %b%b%b exp %b%b%b",
                 wakeReq, coreRst, cpuHalt, mWake[0], mRst[0], mHalt[0]);
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(posedge clk); #2;
    regWe = 1'b0; regWdata = '0;
  endtask

  task automatic chkRd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    regAddr = a;
    @(negedge clk);
    tests++;
    if (regRdata !== exp) begin
      fails++;
      $display("FAIL %s read %h: got %h exp %h", tag, a, regRdata, exp);
    end
    @(posedge clk); #2;
  endtask

  task automatic chkBit(input logic act, input logic exp, input string tag);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %b exp %b", tag, act, exp);
    end
  endtask

  task automatic doReset(input logic strap);
    bootStrap = strap; rst = 1'b1;
    repeat (3) @(posedge clk);
    #2 rst = 1'b0;
  endtask

  initial begin
    doReset(1'b1);
    chkBit(cpuHalt, 1'b0, "R7 halt from strap=1");
    chkRd(8'h08, 32'h0, "R7 halt reg");
    chkRd(8'h00, 32'h0, "R1 sleep reset");
    chkRd(8'h0C, 32'd16, "R9 delay reset");
    chkBit(coreRst, 1'b0, "R4 reset state");

    // wake with delay 3
    wr(8'h0C, 32'd3);
    wr(8'h00, 32'h1);
    chkBit(wakeReq, 1'b1, "R1 wakeReq high");
    regAddr = 8'h00;
    repeat (2) @(posedge clk); #2;
    chkRd(8'h00, 32'h1, "R2 not ready at cnt 2");
    chkRd(8'h00, 32'h5, "R2 ready after delay");

    coreReady = 1'b0;
    chkRd(8'h00, 32'h1, "R2 core not ready");
    coreReady = 1'b1;

    wr(8'h00, 32'h1);
    chkRd(8'h00, 32'h5, "R11 rewake no restart");

    wr(8'h00, 32'h0);
    chkBit(wakeReq, 1'b0, "R1 wakeReq low");
    chkRd(8'h00, 32'h0, "R3 sleep drops ready");

    // zero delay
    wr(8'h0C, 32'd0);
    wr(8'h00, 32'h1);
    chkRd(8'h00, 32'h5, "R9 zero delay ready");

    // soft reset interaction
    wr(8'h0C, 32'd2);
    wr(8'h04, 32'h1);
    chkBit(coreRst, 1'b1, "R4 coreRst set");
    chkRd(8'h00, 32'h1, "R5 not ready in reset");
    repeat (5) @(posedge clk); #2;
    chkRd(8'h04, 32'h1, "R4 no self clear");
    chkRd(8'h08, 32'h0, "R6 halt kept");
    chkRd(8'h0C, 32'd2, "R6 delay kept");
    chkRd(8'h00, 32'h1, "R6 wake kept");
    wr(8'h04, 32'h0);
    chkRd(8'h00, 32'h1, "R5 cnt0 after release");
    chkRd(8'h00, 32'h1, "R5 cnt1 after release");
    chkRd(8'h00, 32'h5, "R5 ready after full delay");

    // halt control
    wr(8'h08, 32'h1);
    chkBit(cpuHalt, 1'b1, "R8 halt set");
    wr(8'h08, 32'h0);
    chkBit(cpuHalt, 1'b0, "R8 halt clear");

    // reserved bits and unmapped space
    wr(8'h04, 32'hFFFF_FFFE);
    chkRd(8'h04, 32'h0, "R10 reserved rst bits");
    wr(8'h00, 32'hFFFF_FFFF);
    chkRd(8'h00, 32'h5, "R10 reserved sleep bits");
    wr(8'h0C, 32'hFFFF_FF05);
    chkRd(8'h0C, 32'h5, "R10 reserved delay bits");
    wr(8'h10, 32'hFFFF_FFFF);
    chkRd(8'h10, 32'h0, "R10 unmapped read");
    chkRd(8'h08, 32'h0, "R10 unmapped write no effect");
    chkRd(8'h04, 32'h0, "R10 unmapped write no effect rst");

    // second hardware reset, strap low
    doReset(1'b0);
    chkBit(cpuHalt, 1'b1, "R7 halt from strap=0");
    chkRd(8'h08, 32'h1, "R7 halt reg strap=0");

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule